// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read return path of a memory whose programming cycles are self-timed. While the array reports a programming cycle in progress, every read returns a status word instead of stored data, so a host can find out when it may start the next access without any extra pin or register. Two separate indications are carried in the same word. The top bit comes back as the inverse of the top bit of the byte most recently written. Bit 6 changes value on every read made during the cycle. A host may watch either one, and may begin watching at any point in the cycle.

Once the busy flag is low, reads return the array data unchanged. The returned byte is registered: a read strobe in one cycle produces the result on the output after the next rising edge, and the output holds that value until the next strobe. The status bit positions and the data width are parameters. The array, output enable timing and any tri-state driver are outside this block.

Top module: `write_status_reporter`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge) rd_data is 0x00 and the alternating status bit is 0, so the first read made while busy returns bit 6 = 0.
- R2: A read strobe with busy low returns arr_data unchanged on rd_data after the next rising edge.
- R3: A read strobe with busy high returns bit 7 of rd_data equal to the inverse of bit 7 of last_byte.
- R4: Successive read strobes with busy high return opposite values on bit 6 of rd_data.
- R5: A read strobe with busy high returns 0 on every rd_data bit other than bits 7 and 6.
- R6: A read strobe in the first cycle in which busy is low, after busy was high in the cycle before, returns true array data on all eight bits.
- R7: Without a read strobe rd_data keeps its value and the bit 6 state does not change, whatever busy, last_byte and arr_data do.
- R8: Reads made while busy is low leave the bit 6 state alone: the first busy read after them returns the inverse of the last busy read before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_stb | input | 1 | One-cycle read request |
| busy | input | 1 | High while the array programming cycle runs |
| last_byte | input | 8 | Byte most recently written to the array |
| arr_data | input | 8 | Data read from the array at the current address |
| rd_data | output | 8 | Registered read result |

## Verification
The assertions check on every cycle that a busy read returns the inverted top bit and zero low bits, that an idle read returns array data one edge later, that the alternating state flips exactly on busy reads and that the output holds without a strobe. Only the bench's scenarios show the longer patterns: the absolute value of bit 6 after reset, its continuity across idle reads, the read in the cycle busy drops, and sweeps of all 256 array and last-byte values.

// File: rtl/wcs_pkg.sv
// Package: shared parameters for the write completion status reporter.
// Assumes: data bytes are 8 bits wide with two status bit positions in them.
package wcs_pkg;
    localparam int unsigned WCS_DATA_W     = 8;
    localparam int unsigned WCS_POLL_BIT   = 7;
    localparam int unsigned WCS_TOGGLE_BIT = 6;

    // Selects what a bit of the busy-time word carries.
    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_POLL   = 2'd1,
        SRC_TOGGLE = 2'd2
    } bit_src_e;

    // Source of bit position idx in the status word.
    function automatic bit_src_e bit_source(input int unsigned idx,
                                            input int unsigned poll_bit,
                                            input int unsigned tgl_bit);
        if (idx == poll_bit)     return SRC_POLL;
        else if (idx == tgl_bit) return SRC_TOGGLE;
        else                     return SRC_ZERO;
    endfunction
endpackage

// File: rtl/wcs_toggle.sv
// Module: wcs_toggle
// Holds the alternating status bit. It flips once for each read strobe that
// arrives while busy is high and keeps its value otherwise, including across
// idle reads. Assumes rd_stb is a one-cycle pulse per read.
module wcs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    input  logic busy,
    output logic tgl
);
    logic flip;

    // Purpose: a busy-time read is the only event that advances the bit.
    always_comb flip = rd_stb & busy;

    // Purpose: state register, cleared by reset, inverted on each flip.
    always_ff @(posedge clk) begin
        if (!rst_n)    tgl <= 1'b0;
        else if (flip) tgl <= ~tgl;
    end

    // R4
    tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (tgl != $past(tgl)));
    // R7
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && busy) |=> $stable(tgl));
endmodule

// File: rtl/wcs_status_word.sv
// Module: wcs_status_word
// Builds the word returned during a programming cycle: the poll bit is the
// inverse of the same bit of the last written byte, the toggle bit carries
// the alternating state, every other bit is zero. Purely combinational.
module wcs_status_word #(
    parameter int unsigned DATA_W     = wcs_pkg::WCS_DATA_W,
    parameter int unsigned POLL_BIT   = wcs_pkg::WCS_POLL_BIT,
    parameter int unsigned TOGGLE_BIT = wcs_pkg::WCS_TOGGLE_BIT
) (
    input  logic [DATA_W-1:0] last_byte,
    input  logic              tgl,
    output logic [DATA_W-1:0] status
);
    import wcs_pkg::*;

    // One selector per bit, chosen at elaboration.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam bit_src_e SRC = bit_source(i, POLL_BIT, TOGGLE_BIT);
        if (SRC == SRC_POLL) begin : g_poll
            // Purpose: inverted copy of the written bit.
            always_comb status[i] = ~last_byte[i];
        end else if (SRC == SRC_TOGGLE) begin : g_tgl
            // Purpose: alternating state.
            always_comb status[i] = tgl;
        end else begin : g_zero
            // Purpose: unused positions read as zero.
            always_comb status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/wcs_read_reg.sv
// Module: wcs_read_reg
// Output register of the read path. On a strobe it captures either the
// status word (busy high) or the array data (busy low); without a strobe it
// holds. Assumes busy is sampled in the strobe cycle itself.
module wcs_read_reg #(
    parameter int unsigned DATA_W = wcs_pkg::WCS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              busy,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] sel;

    // Purpose: pick the source for this read.
    always_comb sel = busy ? status : arr_data;

    // Purpose: capture the selected byte on a read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_stb) rd_q <= sel;
    end

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_q));
endmodule

// File: rtl/write_status_reporter.sv
// Module: write_status_reporter (top)
// Read-path status reporter for a self-timed memory. While busy, reads
// return a status word (inverted poll bit, alternating toggle bit, zeros);
// when idle, reads return array data. Result is registered, one edge after
// the strobe. Assumes rd_stb is a single-cycle request.
module write_status_reporter #(
    parameter int unsigned DATA_W     = wcs_pkg::WCS_DATA_W,
    parameter int unsigned POLL_BIT   = wcs_pkg::WCS_POLL_BIT,
    parameter int unsigned TOGGLE_BIT = wcs_pkg::WCS_TOGGLE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] STATUS_MASK =
        (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

    logic              tgl;
    logic [DATA_W-1:0] status;

    wcs_toggle u_tgl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (rd_stb),
        .busy   (busy),
        .tgl    (tgl)
    );

    wcs_status_word #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (POLL_BIT),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_word (
        .last_byte (last_byte),
        .tgl       (tgl),
        .status    (status)
    );

    wcs_read_reg #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .busy     (busy),
        .status   (status),
        .arr_data (arr_data),
        .rd_q     (rd_data)
    );

    // R3
    poll_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rd_data[POLL_BIT] == !$past(last_byte[POLL_BIT])));
    // R5
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> ((rd_data & ~STATUS_MASK) == '0));
    // R2
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy) |=> (rd_data == $past(arr_data)));
    // R4
    tgl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rd_data[TOGGLE_BIT] == $past(tgl)));
endmodule

// File: tb/write_status_reporter_test.sv
module write_status_reporter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_stb = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] last_byte = 8'h00;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;

    int compared = 0;
    int mismatched = 0;
    logic tgl_exp = 1'b0;
    logic last_busy_t = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    write_status_reporter uut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy),
        .last_byte(last_byte), .arr_data(arr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Issue one read in the next cycle; returns after the result is visible.
    task automatic do_read(input logic b, input logic [7:0] lb, input logic [7:0] ad);
        @(negedge clk);
        busy = b; last_byte = lb; arr_data = ad; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    function automatic logic [7:0] busy_word(input logic [7:0] lb, input logic t);
        return {~lb[7], t, 6'b0};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state of the output
        check("R1", rd_data, 8'h00);

        // R1: first busy read after reset shows toggle 0
        do_read(1'b1, 8'h00, 8'hFF);
        check("R1", rd_data, busy_word(8'h00, 1'b0));
        tgl_exp = 1'b1;

        // R3 R4 R5: sweep every last_byte value, array data scrambled
        for (int v = 0; v < 256; v++) begin
            do_read(1'b1, 8'(v), 8'(v * 37 + 11));
            check("R3", {rd_data[7], 7'b0}, {~v[7], 7'b0});
            check("R5", rd_data & 8'h3F, 8'h00);
            check("R4", {7'b0, rd_data[6]}, {7'b0, tgl_exp});
            last_busy_t = tgl_exp;
            tgl_exp = ~tgl_exp;
        end

        // R2: sweep every array value while idle
        for (int v = 0; v < 256; v++) begin
            do_read(1'b0, 8'(255 - v), 8'(v));
            check("R2", rd_data, 8'(v));
        end

        // R8: after idle reads, next busy read inverts the last busy read
        do_read(1'b1, 8'h80, 8'h00);
        check("R8", rd_data, busy_word(8'h80, ~last_busy_t));
        last_busy_t = ~last_busy_t;
        tgl_exp = ~last_busy_t;

        // R6: busy high one cycle, read in the cycle it drops
        @(negedge clk);
        busy = 1'b1;
        do_read(1'b0, 8'h00, 8'hC3);
        check("R6", rd_data, 8'hC3);

        // R7: no strobe, inputs wander, output holds
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            busy = k[0]; last_byte = 8'(k * 13); arr_data = 8'(k * 29 + 5);
            @(negedge clk);
            check("R7", rd_data, 8'hC3);
        end
        // R7: toggle state unchanged by the strobe-less busy cycles
        do_read(1'b1, 8'h7F, 8'h00);
        check("R7", rd_data, busy_word(8'h7F, tgl_exp));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule